// File: doc/BRIEF.md
# Square-Wave / Alarm Interrupt Pin Controller

This block drives one shared output pin of a real-time clock. The pin carries one of two signals. The first is a square wave, divided from a 32.768 kHz timebase to one of four rates. The second is an active-low, open-drain alarm interrupt. An 8-bit control register sets which signal the pin carries, the square-wave rate, and the enable for each alarm. The same register also holds the battery-mode options: one keeps the pin driving while on battery, and one stops the timebase while on battery.

Two alarm match pulses come from the compare logic outside this block. Each pulse sets a sticky flag. Software clears a flag by writing a 0 to its bit on the flag-clear port. The interrupt stays asserted while any enabled flag is set and the pin is in interrupt mode. When the part runs from battery and the battery-drive option is off, the pin is released to high impedance. All ports are plain single-cycle strobes and levels. The block has no valid/ready interface and no back-pressure: a write, a match pulse or a clear strobe takes effect on the clock edge that samples it.

Top module: `sqw_irq_ctrl`

## Requirements
- R1: After reset the control register reads 0x1C and both alarm flags are 0. Register layout: bit7 oscillator-stop-on-battery, bit6 battery-drive, bit5 convert (stored only), bits4:3 rate, bit2 pin-mode (1 = interrupt), bit1 alarm-2 enable, bit0 alarm-1 enable.
- R2: When `wr_en` is high, `ctrl_q` takes the value of `wr_data` on the next clock edge.
- R3: With the pin in square-wave mode, each half-period lasts a fixed number of timebase ticks: 16384 for rate 00, 16 for rate 01, 4 for rate 10 and 2 for rate 11. These give 1 Hz, 1.024 kHz, 4.096 kHz and 8.192 kHz, and the wave has a 50% duty cycle.
- R4: A write that changes the rate bits restarts the divider. The wave goes low at once, and the first high level starts one full half-period after the write.
- R5: A match pulse on `alm_match[i]` sets `alm_flag[i]` whatever the pin mode and the enables. Bit 0 is alarm 1 and bit 1 is alarm 2.
- R6: When `flag_clr_en` is high, each flag whose bit in `flag_clr_val` is 0 is cleared. A 1 in that bit leaves the flag unchanged.
- R7: A clear and a new match on the same flag in the same cycle leave the flag set.
- R8: In interrupt mode the pin drives low (`pin_oe`=1, `pin_val`=0) only when some alarm has both its flag and its enable set. Otherwise the pin is released (`pin_oe`=0).
- R9: In square-wave mode the pin is driven (`pin_oe`=1) and `pin_val` follows the square wave. Alarm flags still set but do not drive the pin.
- R10: On battery (`on_batt`=1) with battery-drive=0 the pin is released (`pin_oe`=0). With battery-drive=1 the pin works as it does on primary power.
- R11: On battery with oscillator-stop=1 the timebase is gated, so the square wave holds its level. On primary power the oscillator-stop bit has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write value |
| tick | input | 1 | One-cycle 32.768 kHz timebase enable |
| alm_match | input | 2 | Alarm match pulses (bit0 alarm 1, bit1 alarm 2) |
| flag_clr_en | input | 1 | Flag clear strobe |
| flag_clr_val | input | 2 | Written flag values; a 0 clears that flag |
| on_batt | input | 1 | 1 while running from battery |
| ctrl_q | output | 8 | Current control register |
| alm_flag | output | 2 | Sticky alarm flags |
| pin_val | output | 1 | Value driven on the shared pin |
| pin_oe | output | 1 | Pin output enable (0 = high impedance) |

## Verification
The bench measures every half-period in ticks at all four rates. A divider with an off-by-one limit, or one that does not restart when the rate changes, gives edges one tick early or late, or a runt first pulse. It sets a clear and a match on the same flag in one cycle. A design that lets the clear win loses that alarm. It checks the combinations of pin mode and enable: a flag set while its enable is off, or while the pin is in square-wave mode, must not pull the pin low. Last, it runs the two battery rules in both states. A design that drives the pin while it should be released, stops the timebase on primary power, or keeps counting when the oscillator is stopped on battery, shows the wrong pin level or the wrong output enable.

// File: rtl/sqw_pkg.sv
package sqw_pkg;
  localparam int NUM_ALM = 2;

  typedef struct packed {
    logic       osc_stop;   // bit 7
    logic       batt_drive; // bit 6
    logic       conv;       // bit 5
    logic [1:0] rate;       // bits 4:3
    logic       irq_mode;   // bit 2
    logic       ie2;        // bit 1
    logic       ie1;        // bit 0
  } ctrl_t;

  localparam ctrl_t CTRL_RST = 8'h1C;
endpackage

// File: rtl/sqw_ctrl_reg.sv
module sqw_ctrl_reg
  import sqw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output ctrl_t      ctrl_q,
  output logic       rate_restart
);
  ctrl_t nxt;
  assign nxt = ctrl_t'(wr_data);
  assign rate_restart = wr_en && (nxt.rate != ctrl_q.rate);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ctrl_q <= CTRL_RST;
    else if (wr_en) ctrl_q <= nxt;
  end

  // R2
  wr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ctrl_q == $past(wr_data)));
endmodule

// File: rtl/sqw_divider.sv
module sqw_divider #(
  parameter int TB_HZ = 32768
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       restart,
  input  logic [1:0] rate,
  output logic       sq
);
  localparam int H0 = TB_HZ / 2;
  localparam int H1 = TB_HZ / 2048;
  localparam int H2 = TB_HZ / 8192;
  localparam int H3 = TB_HZ / 16384;
  localparam int CW = $clog2(H0 + 1);

  logic [CW-1:0] cnt, lim;

  always_comb begin
    unique case (rate)
      2'b00:   lim = CW'(H0 - 1);
      2'b01:   lim = CW'(H1 - 1);
      2'b10:   lim = CW'(H2 - 1);
      default: lim = CW'(H3 - 1);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      sq  <= 1'b0;
    end else if (restart) begin
      cnt <= '0;
      sq  <= 1'b0;
    end else if (tick_en) begin
      if (cnt >= lim) begin
        cnt <= '0;
        sq  <= ~sq;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R4
  restart_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!sq && cnt == '0));
  // R11
  frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !restart) |=> ($stable(sq) && $stable(cnt)));
endmodule

// File: rtl/sqw_alarm_flags.sv
module sqw_alarm_flags
  import sqw_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_ALM-1:0] match,
  input  logic               clr_en,
  input  logic [NUM_ALM-1:0] clr_val,
  output logic [NUM_ALM-1:0] flag
);
  for (genvar i = 0; i < NUM_ALM; i++) begin : g_flag
    logic clr_i;
    assign clr_i = clr_en && !clr_val[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flag[i] <= 1'b0;
      else if (match[i]) flag[i] <= 1'b1;
      else if (clr_i)    flag[i] <= 1'b0;
    end

    // R5 R7
    match_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      match[i] |=> flag[i]);
    // R6
    clear_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !match[i]) |=> !flag[i]);
    // R6
    hold_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag[i] && !clr_i) |=> flag[i]);
  end
endmodule

// File: rtl/sqw_irq_ctrl.sv
module sqw_irq_ctrl
  import sqw_pkg::*;
#(
  parameter int TB_HZ = 32768
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       tick,
  input  logic [1:0] alm_match,
  input  logic       flag_clr_en,
  input  logic [1:0] flag_clr_val,
  input  logic       on_batt,
  output logic [7:0] ctrl_q,
  output logic [1:0] alm_flag,
  output logic       pin_val,
  output logic       pin_oe
);
  ctrl_t ctrl;
  logic  restart, tick_en, sq, irq, released;

  sqw_ctrl_reg u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .ctrl_q(ctrl), .rate_restart(restart)
  );

  assign tick_en = tick && !(on_batt && ctrl.osc_stop);

  sqw_divider #(.TB_HZ(TB_HZ)) u_div (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .restart(restart),
    .rate(ctrl.rate), .sq(sq)
  );

  sqw_alarm_flags u_flags (
    .clk(clk), .rst_n(rst_n), .match(alm_match), .clr_en(flag_clr_en),
    .clr_val(flag_clr_val), .flag(alm_flag)
  );

  assign irq      = |(alm_flag & {ctrl.ie2, ctrl.ie1});
  assign released = on_batt && !ctrl.batt_drive;
  assign pin_oe   = !released && (ctrl.irq_mode ? irq : 1'b1);
  assign pin_val  = ctrl.irq_mode ? 1'b0 : sq;
  assign ctrl_q   = ctrl;

  // R10
  batt_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (on_batt && !ctrl_q[6]) |-> !pin_oe);
  // R8
  irq_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[2] && pin_oe) |-> (!pin_val && (alm_flag != 2'b00)));
  // R11
  osc_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (on_batt && ctrl_q[7] && !restart) |=> $stable(sq));
endmodule

// File: tb/tb_sqw_irq_ctrl.sv
module tb_sqw_irq_ctrl;
  logic       clk = 0, rst_n = 0;
  logic       wr_en = 0, tick = 0, flag_clr_en = 0, on_batt = 0;
  logic [7:0] wr_data = 0;
  logic [1:0] alm_match = 0, flag_clr_val = 2'b11;
  logic [7:0] ctrl_q;
  logic [1:0] alm_flag;
  logic       pin_val, pin_oe;
  int total = 0, bad = 0;

  sqw_irq_ctrl dut (.*);

  always #2.5 clk = ~clk;

  // {rate code, half-period in ticks}
  localparam int VEC [4][2] = '{'{2, 4}, '{1, 16}, '{0, 16384}, '{3, 2}};

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk); wr_en = 1; wr_data = v;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic measure(input logic lvl, output int n);
    n = 0;
    do begin
      @(negedge clk); n++;
    end while (pin_val != lvl && n < 40000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1
    chk(ctrl_q == 8'h1C, "R1 reset ctrl", ctrl_q, 8'h1C);
    chk(alm_flag == 2'b00, "R1 reset flags", alm_flag, 0);
    rst_n = 1;
    // R2
    wr(8'hA5);
    chk(ctrl_q == 8'hA5, "R2 write", ctrl_q, 8'hA5);
    wr(8'h1C);
    chk(ctrl_q == 8'h1C, "R2 write back", ctrl_q, 8'h1C);

    // R3 R4 R9: rate table, tick every cycle, square-wave mode
    tick = 1;
    foreach (VEC[k]) begin
      wr(8'(VEC[k][0] << 3));
      chk(pin_val == 1'b0 && pin_oe, "R4 restart low", pin_val, 0);
      measure(1'b1, n);
      chk(n == VEC[k][1], "R4/R3 first high", n, VEC[k][1]);
      measure(1'b0, n);
      chk(n == VEC[k][1], "R3 high time", n, VEC[k][1]);
      measure(1'b1, n);
      chk(n == VEC[k][1], "R3 low time", n, VEC[k][1]);
    end

    // R9: flags set in square-wave mode do not pull pin
    @(negedge clk); alm_match = 2'b11;
    @(negedge clk); alm_match = 2'b00;
    chk(alm_flag == 2'b11, "R5 flags in sqw mode", alm_flag, 3);
    chk(pin_oe == 1'b1, "R9 sqw drives", pin_oe, 1);
    measure(1'b1, n); measure(1'b0, n);
    chk(n == 2, "R9 wave still runs", n, 2);

    // R6 clear with mixed bits
    @(negedge clk); flag_clr_en = 1; flag_clr_val = 2'b10;
    @(negedge clk); flag_clr_en = 0; flag_clr_val = 2'b11;
    chk(alm_flag == 2'b10, "R6 clear alarm1 only", alm_flag, 2);
    @(negedge clk); flag_clr_en = 1; flag_clr_val = 2'b01;
    @(negedge clk); flag_clr_en = 0; flag_clr_val = 2'b11;
    chk(alm_flag == 2'b00, "R6 clear alarm2", alm_flag, 0);

    // R8 interrupt mode, enables off
    wr(8'h1C);
    chk(pin_oe == 1'b0, "R8 idle released", pin_oe, 0);
    @(negedge clk); alm_match = 2'b01;
    @(negedge clk); alm_match = 2'b00;
    chk(alm_flag == 2'b01 && !pin_oe, "R8 flag without enable", pin_oe, 0);
    wr(8'h1D);
    chk(pin_oe && !pin_val, "R8 alarm1 irq", pin_oe, 1);
    wr(8'h1E);
    chk(!pin_oe, "R8 wrong enable", pin_oe, 0);
    @(negedge clk); alm_match = 2'b10;
    @(negedge clk); alm_match = 2'b00;
    chk(pin_oe && !pin_val, "R8 alarm2 irq", pin_oe, 1);
    // R7 clear and match same cycle
    @(negedge clk); flag_clr_en = 1; flag_clr_val = 2'b00; alm_match = 2'b10;
    @(negedge clk); flag_clr_en = 0; flag_clr_val = 2'b11; alm_match = 2'b00;
    chk(alm_flag == 2'b10, "R7 match wins", alm_flag, 2);
    chk(pin_oe, "R7 irq held", pin_oe, 1);
    @(negedge clk); flag_clr_en = 1; flag_clr_val = 2'b00;
    @(negedge clk); flag_clr_en = 0; flag_clr_val = 2'b11;
    chk(!pin_oe && alm_flag == 0, "R6 clear releases", pin_oe, 0);

    // R10 battery release / drive
    wr(8'h18);
    @(negedge clk); on_batt = 1;
    @(negedge clk);
    chk(!pin_oe, "R10 batt released", pin_oe, 1'b0);
    wr(8'h58);
    chk(pin_oe, "R10 batt drive", pin_oe, 1);

    // R11 oscillator stop on battery
    wr(8'hD8);
    begin
      logic lv; lv = pin_val;
      repeat (10) begin
        @(negedge clk);
        chk(pin_val == lv, "R11 frozen on batt", pin_val, lv);
      end
    end
    @(negedge clk); on_batt = 0;
    measure(~pin_val, n);
    chk(n <= 2, "R11 runs on primary with osc_stop", n, 2);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule